// File: doc/BRIEF.md
# Display Mode Register Interface

This block is the register front end of a simple linear-framebuffer display controller. One synchronous bus with a single address space reaches two windows. The lower half of the address space holds a bank of 16-bit mode registers, one per halfword. The upper half holds a small window of 32-bit extension registers. One extension register reports the size of that window. The other selects the byte order of the framebuffer.

Two mode-window indices do not read stored data. One returns a fixed identity code. The other returns the framebuffer memory size counted in 64 KiB units. Indices past the end of the bank read as all ones, and writes to them are lost. The byte-order selector only changes when it is written with one of two exact key values. A read is issued with a strobe, and its data comes back from a register one clock later.

Top module: `dmr_regif`

## Requirements
- R1: The address MSB (bit 7 at the default width) selects the window: 0 is the mode window, 1 is the extension window. In the mode window the register index is the byte address shifted right by one, so an odd byte address reaches the same register as the even address below it.
- R2: A read of mode index 0 returns the identity code 0x0000B0C5, whatever was written to that index.
- R3: A read of mode index 10 returns the framebuffer size divided by 65536. The default size is 16 MiB, so the read returns 0x00000100.
- R4: A read of any other mode index at or above the bank size (10 registers) returns 0x0000FFFF.
- R5: A write to a mode index at or above the bank size changes no register of the bank.
- R6: A write to an in-range mode index stores the low 16 bits of the write data. A read returns those 16 bits with bits 31:16 zero. A read and a write to the same register in one cycle return the old value.
- R7: Extension offset 0 reads as the window size, 8. Every other extension offset except 4 reads as zero.
- R8: Extension offset 4 reads 0x1E1E1E1E for little-endian and 0xBEBEBEBE for big-endian. A write there with exactly one of those values selects that order. Any other value leaves the order unchanged.
- R9: After reset every mode register is zero, the byte order is little-endian, and the read data and valid outputs are zero.
- R10: The read-valid output is high in exactly the cycle after a read strobe. The read data changes only in that cycle.
- R11: An extension access whose offset is not a multiple of 4 reads as zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address; the MSB selects the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The assertions check the following on every cycle:
- the one-cycle read latency;
- the identity, memory-size and all-ones return values of the mode window;
- that out-of-range writes leave the bank frozen;
- that the byte order never moves except on a write of a key value.

Only the bench's scenarios can show the rest:
- that each in-range register keeps its own value;
- that odd byte addresses alias onto the even ones;
- that non-key and misaligned writes leave the read-back order intact;
- the read-before-write ordering within one cycle.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    localparam logic [HALF_W-1:0] ID_CODE     = 16'hB0C5;
    localparam logic [WORD_W-1:0] ORDER_LITTLE = 32'h1E1E_1E1E;
    localparam logic [WORD_W-1:0] ORDER_BIG    = 32'hBEBE_BEBE;
    localparam logic [WORD_W-1:0] EXT_WIN_BYTES = 32'd8;

    typedef enum logic {
        WIN_MODE = 1'b0,
        WIN_EXT  = 1'b1
    } win_e;

    typedef enum logic [1:0] {
        SRC_STORED,
        SRC_ID,
        SRC_MEMSZ,
        SRC_ONES
    } mode_src_e;

    typedef enum logic {
        BYTES_LITTLE = 1'b0,
        BYTES_BIG    = 1'b1
    } byte_order_e;

    function automatic logic is_order_key(input logic [WORD_W-1:0] v);
        return (v == ORDER_LITTLE) || (v == ORDER_BIG);
    endfunction
endpackage

// File: rtl/dmr_mode_bank.sv
module dmr_mode_bank
    import dmr_pkg::*;
#(
    parameter int NUM_REGS  = 10,
    parameter int IDX_W     = 7,
    parameter int ID_IDX    = 0,
    parameter int MEMSZ_IDX = 10,
    parameter logic [HALF_W-1:0] MEMSZ_VAL = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata
);
    logic [NUM_REGS-1:0][HALF_W-1:0] regs_q;
    logic [HALF_W-1:0] stored;
    logic in_range;
    mode_src_e src;

    assign in_range = (idx < IDX_W'(NUM_REGS));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                regs_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        stored = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) stored = regs_q[i];
        end
    end

    always_comb begin
        if (idx == IDX_W'(ID_IDX))         src = SRC_ID;
        else if (idx == IDX_W'(MEMSZ_IDX)) src = SRC_MEMSZ;
        else if (!in_range)                src = SRC_ONES;
        else                               src = SRC_STORED;
    end

    always_comb begin
        unique case (src)
            SRC_ID:    rdata = ID_CODE;
            SRC_MEMSZ: rdata = MEMSZ_VAL;
            SRC_ONES:  rdata = '1;
            default:   rdata = stored;
        endcase
    end

    // R5: out-of-range writes leave the whole bank untouched
    assert_drop_oor_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(regs_q));
endmodule

// File: rtl/dmr_ext_regs.sv
module dmr_ext_regs
    import dmr_pkg::*;
#(
    parameter int OFF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [OFF_W-1:0] SIZE_OFF  = OFF_W'(0);
    localparam logic [OFF_W-1:0] ORDER_OFF = OFF_W'(4);

    byte_order_e order_q;
    logic hit_order;

    assign hit_order = (off == ORDER_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= BYTES_LITTLE;
        end else if (wr_en && hit_order) begin
            if (wdata == ORDER_BIG)         order_q <= BYTES_BIG;
            else if (wdata == ORDER_LITTLE) order_q <= BYTES_LITTLE;
        end
    end

    always_comb begin
        if (off == SIZE_OFF)  rdata = EXT_WIN_BYTES;
        else if (hit_order)   rdata = (order_q == BYTES_BIG) ? ORDER_BIG : ORDER_LITTLE;
        else                  rdata = '0;
    end

    // R8: the order moves only on a key-valued write to its offset
    assert_order_key_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(order_q) |-> $past(wr_en && hit_order && is_order_key(wdata)));

    // R8: read-back of the order register is always one of the keys
    assert_order_read_R8: assert property (@(posedge clk) disable iff (rst)
        hit_order |-> is_order_key(rdata));
endmodule

// File: rtl/dmr_regif.sv
module dmr_regif
    import dmr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_REGS   = 10,
    parameter int ID_IDX     = 0,
    parameter int MEMSZ_IDX  = 10,
    parameter longint VRAM_BYTES = 64'd16777216
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    localparam int OFF_W = ADDR_W - 1;
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [HALF_W-1:0] MEMSZ_VAL = HALF_W'(VRAM_BYTES / 65536);

    win_e win;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic [HALF_W-1:0] mode_rdata;
    logic [WORD_W-1:0] ext_rdata;
    logic mode_wr, ext_wr;

    assign win     = win_e'(bus_addr[ADDR_W-1]);
    assign idx     = bus_addr[ADDR_W-2:1];
    assign off     = bus_addr[ADDR_W-2:0];
    assign mode_wr = bus_wr && (win == WIN_MODE);
    assign ext_wr  = bus_wr && (win == WIN_EXT) && (off[1:0] == 2'b00);

    dmr_mode_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .ID_IDX   (ID_IDX),
        .MEMSZ_IDX(MEMSZ_IDX),
        .MEMSZ_VAL(MEMSZ_VAL)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr_en(mode_wr),
        .idx  (idx),
        .wdata(bus_wdata[HALF_W-1:0]),
        .rdata(mode_rdata)
    );

    dmr_ext_regs #(.OFF_W(OFF_W)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .wr_en(ext_wr),
        .off  (off),
        .wdata(bus_wdata),
        .rdata(ext_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                if (win == WIN_EXT)
                    bus_rdata <= (off[1:0] == 2'b00) ? ext_rdata : '0;
                else
                    bus_rdata <= WORD_W'(mode_rdata);
            end
        end
    end

    // R10: valid follows the strobe by exactly one clock
    assert_rvalid_lat_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (!bus_rvalid && $stable(bus_rdata)));
    // R2: identity index
    assert_id_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && win == WIN_MODE && idx == IDX_W'(ID_IDX))
        |=> bus_rdata == WORD_W'(ID_CODE));
    // R3: memory-size index
    assert_memsz_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && win == WIN_MODE && idx == IDX_W'(MEMSZ_IDX))
        |=> bus_rdata == WORD_W'(MEMSZ_VAL));
    // R4: unmapped mode indices read all ones
    assert_oor_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && win == WIN_MODE && idx >= IDX_W'(NUM_REGS)
         && idx != IDX_W'(MEMSZ_IDX) && idx != IDX_W'(ID_IDX))
        |=> bus_rdata == 32'h0000_FFFF);
endmodule

// File: tb/tb_dmr_regif.sv
module tb_dmr_regif;
    import dmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    int mregs [10];
    bit m_big = 0;
    bit exp_rv = 0;
    logic [31:0] exp_rd = '0;
    string exp_tag = "R10";

    always #10 clk = ~clk;

    dmr_regif dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int o, i;
        if (a[7]) begin
            o = int'(a[6:0]);
            if (o == 0) return 32'd8;
            if (o == 4) return m_big ? 32'hBEBE_BEBE : 32'h1E1E_1E1E;
            return 32'd0;
        end
        i = int'(a[6:1]);
        if (i == 0) return 32'h0000_B0C5;
        if (i == 10) return 32'h0000_0100;
        if (i > 10) return 32'h0000_FFFF;
        return 32'(mregs[i]);
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int i;
        if (a[7]) begin
            if (int'(a[6:0]) == 4) begin
                if (d == 32'hBEBE_BEBE) m_big = 1;
                else if (d == 32'h1E1E_1E1E) m_big = 0;
            end
        end else begin
            i = int'(a[6:1]);
            if (i < 10) mregs[i] = int'(d[15:0]);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // compares at the negedge the model's expectation with the ports, then drives
    task automatic cyc(input bit rd, input bit wr, input logic [7:0] a,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        check(bus_rvalid == exp_rv, "R10", {31'd0, bus_rvalid}, {31'd0, exp_rv});
        if (exp_rv) check(bus_rdata == exp_rd, exp_tag, bus_rdata, exp_rd);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        exp_rv = rd;
        if (rd) begin
            exp_rd = model_read(a);
            exp_tag = tag;
        end
        if (wr) model_write(a, d);
    endtask

    task automatic rd_at(input logic [7:0] a, input string tag);
        cyc(1, 0, a, 32'h0, tag);
    endtask

    task automatic wr_at(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(0, 1, a, d, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) mregs[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state of the outputs
        check(bus_rdata == 32'h0 && bus_rvalid == 1'b0, "R9", bus_rdata, 32'h0);
        for (int i = 1; i < 10; i++) rd_at(8'(2 * i), "R9");
        rd_at(8'h84, "R9");

        // R6: store low halfword, read back with upper bits zero
        for (int i = 1; i < 10; i++) wr_at(8'(2 * i), 32'hA5A5_0000 | 32'(i * 32'h1111), "R6");
        for (int i = 1; i < 10; i++) rd_at(8'(2 * i), "R6");
        // R6: read and write in one cycle returns the old value
        cyc(1, 1, 8'h06, 32'h0000_3C3C, "R6");
        rd_at(8'h06, "R6");

        // R1: odd byte address aliases the even one
        wr_at(8'h09, 32'h0000_5A5A, "R1");
        rd_at(8'h08, "R1");
        rd_at(8'h0B, "R1");

        // R2: identity index ignores writes
        rd_at(8'h00, "R2");
        wr_at(8'h00, 32'h0000_1234, "R2");
        rd_at(8'h01, "R2");

        // R3: memory size
        rd_at(8'h14, "R3");
        rd_at(8'h15, "R3");

        // R4: out-of-range reads
        rd_at(8'h16, "R4");
        rd_at(8'h7E, "R4");
        rd_at(8'h7F, "R4");

        // R5: out-of-range writes are dropped; whole bank re-read
        wr_at(8'h18, 32'h0000_7777, "R5");
        wr_at(8'h7E, 32'h0000_8888, "R5");
        wr_at(8'h14, 32'h0000_9999, "R5");
        for (int i = 1; i < 10; i++) rd_at(8'(2 * i), "R5");
        rd_at(8'h14, "R5");

        // R7: size register and unmapped offsets
        rd_at(8'h80, "R7");
        rd_at(8'h88, "R7");
        rd_at(8'hFC, "R7");
        wr_at(8'h80, 32'hFFFF_FFFF, "R7");
        rd_at(8'h80, "R7");

        // R8: byte order keys
        wr_at(8'h84, 32'hBEBE_BEBE, "R8");
        rd_at(8'h84, "R8");
        wr_at(8'h84, 32'h1234_5678, "R8");
        rd_at(8'h84, "R8");
        wr_at(8'h84, 32'hBEBE_BEBF, "R8");
        rd_at(8'h84, "R8");
        wr_at(8'h84, 32'h1E1E_1E1E, "R8");
        rd_at(8'h84, "R8");
        wr_at(8'h84, 32'h1E1E_1E1F, "R8");
        rd_at(8'h84, "R8");

        // R11: misaligned extension access
        wr_at(8'h85, 32'hBEBE_BEBE, "R11");
        rd_at(8'h84, "R11");
        rd_at(8'h85, "R11");
        rd_at(8'h81, "R11");

        // R10: idle gaps and back-to-back reads
        cyc(0, 0, 8'h00, 32'h0, "R10");
        cyc(0, 0, 8'h02, 32'h0, "R10");
        rd_at(8'h02, "R10");
        rd_at(8'h04, "R10");
        rd_at(8'h00, "R10");
        cyc(0, 0, 8'h00, 32'h0, "R10");
        cyc(0, 0, 8'h00, 32'h0, "R10");

        finish_run();
    end
endmodule